// File: doc/BRIEF.md
# Field-Synchronous Control Register File

This block is the register-mapped control agent of one video processing stage. Software reaches it over a simple word-oriented read/write bus. The byte offset of each 32-bit word is given on the address, and the two low address bits are ignored. A read strobe returns its data exactly one clock later. The agent serves several kinds of read-only data: identification and parameter words, image-information words, a status word and the field count of the most recent image-information packet. It also holds a bank of staged control registers.

Control words written by software go into shadow copies only. A write to the commit word marks an update as pending. The shadow contents are copied into the active copies, which drive the datapath, only when the datapath signals the start of the next field. Two strobes from the video side, start-of-field and end-of-field, drive a busy flag. The pending flag clears by itself when the copy happens.

A parameter selects between two modes. In lite mode software writes the image-information words. In full mode the words are loaded from image-information packets delivered by the datapath, and bus writes to them have no effect.

Top module: `vfc_field_regs`

## Requirements
- R1: Offset 0x000 reads the identification parameter, 0x004 the version parameter, 0x008 the number of control registers and 0x00C the mode (1 = lite, 0 = full). Every other offset in 0x010–0x11F, offset 0x12C, offset 0x144 and every offset beyond the last control register reads zero.
- R2: Read data appears on `bus_rdata` in the cycle after the one in which `bus_rd` is sampled high. In any cycle that follows a cycle without a read, `bus_rdata` is zero.
- R3: Writes to offsets 0x000–0x11F, 0x12C, 0x13C, 0x140 and every offset beyond the last control register change nothing that can be read or driven out. In full mode, writes to the image-information offsets have no effect either.
- R4: In lite mode, the following writes are stored and read back masked to their field widths: 0x120 width (16 bits), 0x124 height (16), 0x128 interlace (4), 0x130 colour space (8), 0x134 subsampling (4) and 0x138 co-siting (4). `img_info_o` carries them packed as {width, height, interlace, colour space, subsampling, co-siting}, with width in the most significant bits.
- R5: In full mode, a cycle with `pkt_valid` high loads all six image-information fields from the packet inputs. In both modes the same cycle loads offset 0x13C with `pkt_field_count`.
- R6: Status bit 0 at 0x140 goes high the cycle after `sof` is sampled and low the cycle after `eof` is sampled without `sof`. If both strobes come in one cycle, `sof` wins.
- R7: A write to control register i at 0x148+4·i updates its shadow copy, which reads back at once. The matching active word in `act_ctrl` (bits i·32 upward) stays unchanged.
- R8: A write to the commit word at 0x144 sets status bit 1 in the next cycle. A `sof` that is sampled while bit 1 is set copies every shadow word into the active words and clears bit 1 at the same edge.
- R9: `act_ctrl` changes only at an edge where `sof` is sampled with an update pending. It stays constant through the whole of a field and across `eof`.
- R10: A second commit before the field boundary leaves the pending flag set. The transfer then uses the latest shadow values.
- R11: A commit that is sampled in the same cycle as `sof` does not use that boundary unless an update was already pending. It leaves the pending flag set for the next `sof`.
- R12: A `sof` with no pending update leaves `act_ctrl` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the 32-bit word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after `bus_rd` |
| sof | input | 1 | Start-of-field strobe |
| eof | input | 1 | End-of-field strobe |
| pkt_valid | input | 1 | Image-information packet present |
| pkt_width | input | 16 | Packet width field |
| pkt_height | input | 16 | Packet height field |
| pkt_interlace | input | 4 | Packet interlace field |
| pkt_colorspace | input | 8 | Packet colour-space field |
| pkt_subsample | input | 4 | Packet subsampling field |
| pkt_cosite | input | 4 | Packet co-siting field |
| pkt_field_count | input | 16 | Packet field count |
| act_ctrl | output | N_CTRL·DATA_W | Active control words, word i at bits i·DATA_W upward |
| img_info_o | output | 52 | Current image information, packed as in R4 |

## Verification
The bench reads every word offset, first from reset and again after writing all ones to each read-only and reserved offset. This separates faults in address decoding from writes that leak into protected state. The two modes run side by side from the same stimulus, so one image-information write tells a lite instance that stores it from a full instance that must ignore it. Field-boundary transfers are tried in several orders: a commit outside a field, a commit inside a field, two commits before one boundary, a commit in the same cycle as the start strobe, and a start strobe with nothing pending. Each order exposes a different wrong rule about when the active words may change.

// File: rtl/vfc_pkg.sv
package vfc_pkg;

  localparam int unsigned OFS_ID     = 'h000;
  localparam int unsigned OFS_VER    = 'h004;
  localparam int unsigned OFS_NCTRL  = 'h008;
  localparam int unsigned OFS_MODE   = 'h00C;
  localparam int unsigned OFS_WIDTH  = 'h120;
  localparam int unsigned OFS_HEIGHT = 'h124;
  localparam int unsigned OFS_ILACE  = 'h128;
  localparam int unsigned OFS_CSPACE = 'h130;
  localparam int unsigned OFS_SUBS   = 'h134;
  localparam int unsigned OFS_COSITE = 'h138;
  localparam int unsigned OFS_FCOUNT = 'h13C;
  localparam int unsigned OFS_STATUS = 'h140;
  localparam int unsigned OFS_COMMIT = 'h144;
  localparam int unsigned OFS_CTRL0  = 'h148;

  localparam int unsigned INFO_W = 52;

  typedef struct packed {
    logic [15:0] width;
    logic [15:0] height;
    logic [3:0]  interlace;
    logic [7:0]  colorspace;
    logic [3:0]  subsample;
    logic [3:0]  cosite;
  } img_info_t;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ID, SEL_VER, SEL_NCTRL, SEL_MODE,
    SEL_WIDTH, SEL_HEIGHT, SEL_ILACE, SEL_CSPACE, SEL_SUBS, SEL_COSITE,
    SEL_FCOUNT, SEL_STATUS, SEL_COMMIT, SEL_CTRL
  } reg_sel_e;

endpackage

// File: rtl/vfc_decode.sv
module vfc_decode
  import vfc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int N_CTRL = 4,
  parameter int IDX_W  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [IDX_W-1:0]  idx
);

  localparam int unsigned CTRL_END = OFS_CTRL0 + 4 * N_CTRL;

  int unsigned word_ofs;
  int unsigned ctrl_ofs;

  always_comb begin
    word_ofs = int'(addr) & ~32'd3;
    ctrl_ofs = word_ofs - OFS_CTRL0;
    idx      = '0;
    sel      = SEL_NONE;
    if (word_ofs >= OFS_CTRL0 && word_ofs < CTRL_END) begin
      sel = SEL_CTRL;
      idx = IDX_W'(ctrl_ofs >> 2);
    end else begin
      case (word_ofs)
        OFS_ID:     sel = SEL_ID;
        OFS_VER:    sel = SEL_VER;
        OFS_NCTRL:  sel = SEL_NCTRL;
        OFS_MODE:   sel = SEL_MODE;
        OFS_WIDTH:  sel = SEL_WIDTH;
        OFS_HEIGHT: sel = SEL_HEIGHT;
        OFS_ILACE:  sel = SEL_ILACE;
        OFS_CSPACE: sel = SEL_CSPACE;
        OFS_SUBS:   sel = SEL_SUBS;
        OFS_COSITE: sel = SEL_COSITE;
        OFS_FCOUNT: sel = SEL_FCOUNT;
        OFS_STATUS: sel = SEL_STATUS;
        OFS_COMMIT: sel = SEL_COMMIT;
        default:    sel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/vfc_ctrl_bank.sv
module vfc_ctrl_bank #(
  parameter int                N_CTRL  = 4,
  parameter int                DATA_W  = 32,
  parameter int                IDX_W   = 2,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          load,
  output logic [N_CTRL-1:0][DATA_W-1:0] shadow,
  output logic [N_CTRL-1:0][DATA_W-1:0] active
);

  for (genvar g = 0; g < N_CTRL; g++) begin : g_word
    logic sh_en;

    always_comb begin
      sh_en = wr_en && (wr_idx == IDX_W'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow[g] <= RST_VAL;
      end else if (sh_en) begin
        shadow[g] <= wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        active[g] <= RST_VAL;
      end else if (load) begin
        active[g] <= shadow[g];
      end
    end
  end

endmodule

// File: rtl/vfc_img_info.sv
module vfc_img_info
  import vfc_pkg::*;
#(
  parameter bit LITE = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  reg_sel_e    sel,
  input  logic [15:0] wr_data,
  input  logic        pkt_valid,
  input  img_info_t   pkt_info,
  input  logic [15:0] pkt_fcount,
  output img_info_t   info,
  output logic [15:0] fcount
);

  img_info_t info_nxt;
  logic      info_en;
  logic      sw_hit;

  always_comb begin
    sw_hit = (sel == SEL_WIDTH) || (sel == SEL_HEIGHT) || (sel == SEL_ILACE) ||
             (sel == SEL_CSPACE) || (sel == SEL_SUBS) || (sel == SEL_COSITE);
    info_nxt = info;
    if (LITE) begin
      info_en = wr_en && sw_hit;
      case (sel)
        SEL_WIDTH:  info_nxt.width      = wr_data;
        SEL_HEIGHT: info_nxt.height     = wr_data;
        SEL_ILACE:  info_nxt.interlace  = wr_data[3:0];
        SEL_CSPACE: info_nxt.colorspace = wr_data[7:0];
        SEL_SUBS:   info_nxt.subsample  = wr_data[3:0];
        SEL_COSITE: info_nxt.cosite     = wr_data[3:0];
        default:    info_nxt = info;
      endcase
    end else begin
      info_en  = pkt_valid;
      info_nxt = pkt_info;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      info <= '0;
    end else if (info_en) begin
      info <= info_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcount <= '0;
    end else if (pkt_valid) begin
      fcount <= pkt_fcount;
    end
  end

endmodule

// File: rtl/vfc_field_regs.sv
module vfc_field_regs
  import vfc_pkg::*;
#(
  parameter int                ADDR_W  = 10,
  parameter int                DATA_W  = 32,
  parameter int                N_CTRL  = 4,
  parameter bit                LITE    = 1'b1,
  parameter logic [DATA_W-1:0] ID_VAL  = 'h0000_7C31,
  parameter logic [DATA_W-1:0] VER_VAL = 'h0001_0200
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic                     sof,
  input  logic                     eof,
  input  logic                     pkt_valid,
  input  logic [15:0]              pkt_width,
  input  logic [15:0]              pkt_height,
  input  logic [3:0]               pkt_interlace,
  input  logic [7:0]               pkt_colorspace,
  input  logic [3:0]               pkt_subsample,
  input  logic [3:0]               pkt_cosite,
  input  logic [15:0]              pkt_field_count,
  output logic [N_CTRL*DATA_W-1:0] act_ctrl,
  output logic [INFO_W-1:0]        img_info_o
);

  localparam int IDX_W = (N_CTRL > 1) ? $clog2(N_CTRL) : 1;

  reg_sel_e                      sel;
  logic [IDX_W-1:0]              idx;
  logic [N_CTRL-1:0][DATA_W-1:0] shadow;
  logic [N_CTRL-1:0][DATA_W-1:0] active;
  img_info_t                     info;
  img_info_t                     pkt_info;
  logic [15:0]                   fcount;

  logic busy, busy_nxt;
  logic pend, pend_nxt;
  logic commit_wr, ctrl_wr, load;
  logic [DATA_W-1:0] rd_mux, rdata_nxt;

  vfc_decode #(.ADDR_W(ADDR_W), .N_CTRL(N_CTRL), .IDX_W(IDX_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel),
    .idx  (idx)
  );

  always_comb begin
    commit_wr = bus_wr && (sel == SEL_COMMIT);
    ctrl_wr   = bus_wr && (sel == SEL_CTRL);
    load      = sof && pend;
    pkt_info  = '{width: pkt_width, height: pkt_height, interlace: pkt_interlace,
                  colorspace: pkt_colorspace, subsample: pkt_subsample,
                  cosite: pkt_cosite};
  end

  vfc_ctrl_bank #(.N_CTRL(N_CTRL), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ctrl_wr),
    .wr_idx  (idx),
    .wr_data (bus_wdata),
    .load    (load),
    .shadow  (shadow),
    .active  (active)
  );

  vfc_img_info #(.LITE(LITE)) u_info (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (bus_wr),
    .sel        (sel),
    .wr_data    (bus_wdata[15:0]),
    .pkt_valid  (pkt_valid),
    .pkt_info   (pkt_info),
    .pkt_fcount (pkt_field_count),
    .info       (info),
    .fcount     (fcount)
  );

  // Field and pending state, next-state logic.
  always_comb begin
    if (sof) begin
      busy_nxt = 1'b1;
    end else if (eof) begin
      busy_nxt = 1'b0;
    end else begin
      busy_nxt = busy;
    end
    if (commit_wr) begin
      pend_nxt = 1'b1;
    end else if (load) begin
      pend_nxt = 1'b0;
    end else begin
      pend_nxt = pend;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pend <= 1'b0;
    end else begin
      busy <= busy_nxt;
      pend <= pend_nxt;
    end
  end

  // Read path.
  always_comb begin
    case (sel)
      SEL_ID:     rd_mux = ID_VAL;
      SEL_VER:    rd_mux = VER_VAL;
      SEL_NCTRL:  rd_mux = DATA_W'(N_CTRL);
      SEL_MODE:   rd_mux = DATA_W'(LITE);
      SEL_WIDTH:  rd_mux = DATA_W'(info.width);
      SEL_HEIGHT: rd_mux = DATA_W'(info.height);
      SEL_ILACE:  rd_mux = DATA_W'(info.interlace);
      SEL_CSPACE: rd_mux = DATA_W'(info.colorspace);
      SEL_SUBS:   rd_mux = DATA_W'(info.subsample);
      SEL_COSITE: rd_mux = DATA_W'(info.cosite);
      SEL_FCOUNT: rd_mux = DATA_W'(fcount);
      SEL_STATUS: rd_mux = DATA_W'({pend, busy});
      SEL_CTRL:   rd_mux = shadow[idx];
      default:    rd_mux = '0;
    endcase
    rdata_nxt = bus_rd ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= rdata_nxt;
    end
  end

  always_comb begin
    act_ctrl   = active;
    img_info_o = info;
  end

endmodule

// File: rtl/vfc_field_regs_chk.sv
module vfc_field_regs_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int N_CTRL = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_wr,
  input logic                     bus_rd,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic [DATA_W-1:0]        bus_rdata,
  input logic                     sof,
  input logic                     eof,
  input logic [N_CTRL*DATA_W-1:0] act_ctrl,
  input logic [N_CTRL*DATA_W-1:0] shadow,
  input logic                     busy,
  input logic                     pend
);

  logic commit_hit;
  always_comb begin
    commit_hit = bus_wr && ({bus_addr[ADDR_W-1:2], 2'b00} == ADDR_W'('h144));
  end

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == '0); // R2

  AST_BUSY_ON_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> busy); // R6

  AST_BUSY_OFF_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && !sof) |=> !busy); // R6

  AST_PEND_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit_hit |=> pend); // R8

  AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && pend && !commit_hit) |=> !pend); // R8

  AST_ACT_ONLY_AT_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_ctrl) |-> $past(sof && pend)); // R9

  AST_ACT_TAKES_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && pend) |=> act_ctrl == $past(shadow)); // R10

  AST_NO_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && !pend) |=> $stable(act_ctrl)); // R12

endmodule

bind vfc_field_regs vfc_field_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_CTRL(N_CTRL)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .sof       (sof),
  .eof       (eof),
  .act_ctrl  (act_ctrl),
  .shadow    (shadow),
  .busy      (busy),
  .pend      (pend)
);

// File: tb/tb_vfc_field_regs.sv
`timescale 1ns/1ps
module tb_vfc_field_regs;

  localparam int AW = 10;
  localparam int DW = 32;
  localparam int NC = 4;
  localparam logic [31:0] IDV = 'h0000_7C31;
  localparam logic [31:0] VRV = 'h0001_0200;

  logic clk, rst_n;
  logic bus_wr, bus_rd, sof, eof, pkt_valid;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [15:0] pkt_width, pkt_height, pkt_field_count;
  logic [3:0]  pkt_interlace, pkt_subsample, pkt_cosite;
  logic [7:0]  pkt_colorspace;
  logic [DW-1:0] rdata_l, rdata_f;
  logic [NC*DW-1:0] act_l, act_f;
  logic [51:0] info_l, info_f;

  int n_vec = 0;
  int n_bad = 0;

  vfc_field_regs #(.LITE(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_l),
    .sof(sof), .eof(eof), .pkt_valid(pkt_valid), .pkt_width(pkt_width),
    .pkt_height(pkt_height), .pkt_interlace(pkt_interlace),
    .pkt_colorspace(pkt_colorspace), .pkt_subsample(pkt_subsample),
    .pkt_cosite(pkt_cosite), .pkt_field_count(pkt_field_count),
    .act_ctrl(act_l), .img_info_o(info_l));

  vfc_field_regs #(.LITE(1'b0)) dut_full (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_f),
    .sof(sof), .eof(eof), .pkt_valid(pkt_valid), .pkt_width(pkt_width),
    .pkt_height(pkt_height), .pkt_interlace(pkt_interlace),
    .pkt_colorspace(pkt_colorspace), .pkt_subsample(pkt_subsample),
    .pkt_cosite(pkt_cosite), .pkt_field_count(pkt_field_count),
    .act_ctrl(act_f), .img_info_o(info_f));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] reset_val(input bit lite, input int a);
    case (a)
      'h000:   return IDV;
      'h004:   return VRV;
      'h008:   return 32'(NC);
      'h00C:   return 32'(lite);
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [127:0] pack_ctrl(input logic [31:0] base);
    logic [127:0] v;
    for (int i = 0; i < NC; i++) v[i*32 +: 32] = base + 32'(i);
    return v;
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // Issues a read, rdata is valid at the following falling edge.
  task automatic rd(input int a, output logic [31:0] dl, output logic [31:0] df);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    dl = rdata_l; df = rdata_f;
  endtask

  task automatic rd_chk(input string tag, input int a, input logic [31:0] el, input logic [31:0] ef);
    logic [31:0] dl, df;
    rd(a, dl, df);
    chk({tag, " lite"}, 128'(dl), 128'(el));
    chk({tag, " full"}, 128'(df), 128'(ef));
  endtask

  task automatic pulse_sof();
    sof = 1'b1; @(negedge clk); sof = 1'b0;
  endtask

  task automatic pulse_eof();
    eof = 1'b1; @(negedge clk); eof = 1'b0;
  endtask

  function automatic bit protected_ofs(input int a);
    if (a >= 'h120 && a <= 'h138 && a != 'h12C) return 1'b0;
    if (a >= 'h144 && a < 'h148 + 4 * NC) return 1'b0;
    return 1'b1;
  endfunction

  task automatic sweep_reset(input string tag);
    for (int a = 0; a < 1024; a += 4) begin
      rd_chk(tag, a, reset_val(1'b1, a), reset_val(1'b0, a));
    end
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] dl, df;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    sof = 1'b0; eof = 1'b0; pkt_valid = 1'b0;
    pkt_width = '0; pkt_height = '0; pkt_interlace = '0; pkt_colorspace = '0;
    pkt_subsample = '0; pkt_cosite = '0; pkt_field_count = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    chk("reset rdata R2", {64'(rdata_l), 64'(rdata_f)}, 128'h0);
    chk("reset act R9", act_l, 128'h0);
    chk("reset act full R9", act_f, 128'h0);

    // R1: whole address map from reset
    sweep_reset("R1 map");

    // R2: data only in the cycle after the read
    rd(0, dl, df);
    @(negedge clk);
    chk("R2 idle after read", {64'(rdata_l), 64'(rdata_f)}, 128'h0);

    // R3: all-ones to every protected offset, then re-sweep
    for (int a = 0; a < 1024; a += 4) begin
      if (protected_ofs(a)) wr(a, 32'hFFFF_FFFF);
    end
    sweep_reset("R3 protected");
    chk("R3 act", act_l, 128'h0);

    // R4: lite image info written and masked; full ignores (R3)
    for (int a = 'h120; a <= 'h138; a += 4) wr(a, 32'hFFFF_FFFF);
    rd_chk("R4 width",  'h120, 32'hFFFF, 32'h0);
    rd_chk("R4 height", 'h124, 32'hFFFF, 32'h0);
    rd_chk("R4 ilace",  'h128, 32'hF, 32'h0);
    rd_chk("R4 rsvd 12C R1", 'h12C, 32'h0, 32'h0);
    rd_chk("R4 cspace", 'h130, 32'hFF, 32'h0);
    rd_chk("R4 subs",   'h134, 32'hF, 32'h0);
    rd_chk("R4 cosite", 'h138, 32'hF, 32'h0);
    chk("R4 info out", {76'(info_l)}, {76'(52'hF_FFFF_FFFF_FFFF)});
    chk("R3 full info out", 128'(info_f), 128'h0);

    // R5: packet capture
    pkt_width = 16'd1920; pkt_height = 16'd1080; pkt_interlace = 4'd2;
    pkt_colorspace = 8'd5; pkt_subsample = 4'd3; pkt_cosite = 4'd1;
    pkt_field_count = 16'h1234; pkt_valid = 1'b1;
    @(negedge clk);
    pkt_valid = 1'b0;
    rd_chk("R5 width",  'h120, 32'hFFFF, 32'd1920);
    rd_chk("R5 height", 'h124, 32'hFFFF, 32'd1080);
    rd_chk("R5 ilace",  'h128, 32'hF, 32'd2);
    rd_chk("R5 cspace", 'h130, 32'hFF, 32'd5);
    rd_chk("R5 subs",   'h134, 32'hF, 32'd3);
    rd_chk("R5 cosite", 'h138, 32'hF, 32'd1);
    rd_chk("R5 fcount", 'h13C, 32'h1234, 32'h1234);

    // R7: shadow writes only
    for (int i = 0; i < NC; i++) wr('h148 + 4 * i, 32'hA0 + 32'(i));
    for (int i = 0; i < NC; i++) rd_chk("R7 shadow", 'h148 + 4 * i, 32'hA0 + 32'(i), 32'hA0 + 32'(i));
    rd_chk("R1 past ctrl", 'h148 + 4 * NC, 32'h0, 32'h0);
    chk("R7 act held", act_l, 128'h0);

    // R6 + R12: field with nothing pending
    pulse_sof();
    chk("R12 act after sof", act_l, 128'h0);
    rd_chk("R6 busy", 'h140, 32'h1, 32'h1);
    pulse_eof();
    rd_chk("R6 idle", 'h140, 32'h0, 32'h0);

    // R8: commit between fields, applied at the next sof
    wr('h144, 32'h1);
    rd_chk("R8 pending", 'h140, 32'h2, 32'h2);
    rd_chk("R1 commit reads 0", 'h144, 32'h0, 32'h0);
    chk("R8 act before sof", act_l, 128'h0);
    pulse_sof();
    chk("R8 act loaded", act_l, pack_ctrl(32'hA0));
    chk("R8 act loaded full", act_f, pack_ctrl(32'hA0));
    rd_chk("R8 pending cleared", 'h140, 32'h1, 32'h1);

    // R9 + R10: commits inside a field wait for the boundary
    for (int i = 0; i < NC; i++) wr('h148 + 4 * i, 32'hB0 + 32'(i));
    wr('h144, 32'h1);
    rd_chk("R9 pending in field", 'h140, 32'h3, 32'h3);
    repeat (5) @(negedge clk);
    chk("R9 act stable in field", act_l, pack_ctrl(32'hA0));
    pulse_eof();
    chk("R9 act stable at eof", act_l, pack_ctrl(32'hA0));
    for (int i = 0; i < NC; i++) wr('h148 + 4 * i, 32'hC0 + 32'(i));
    wr('h144, 32'h1);
    rd_chk("R10 still pending", 'h140, 32'h2, 32'h2);
    pulse_sof();
    chk("R10 latest shadow", act_l, pack_ctrl(32'hC0));

    // R11: commit coinciding with sof, nothing pending before
    for (int i = 0; i < NC; i++) wr('h148 + 4 * i, 32'hD0 + 32'(i));
    bus_wr = 1'b1; bus_addr = AW'('h144); bus_wdata = 32'h1; sof = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; sof = 1'b0;
    chk("R11 no load at same sof", act_l, pack_ctrl(32'hC0));
    rd_chk("R11 pending kept", 'h140, 32'h3, 32'h3);
    pulse_eof();
    pulse_sof();
    chk("R11 load next sof", act_l, pack_ctrl(32'hD0));
    rd_chk("R11 pending cleared", 'h140, 32'h1, 32'h1);

    // R6: sof wins over eof in the same cycle
    sof = 1'b1; eof = 1'b1;
    @(negedge clk);
    sof = 1'b0; eof = 1'b0;
    rd_chk("R6 sof wins", 'h140, 32'h1, 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule